// File: doc/BRIEF.md
# Single-Precision Rounding Stage with Overflow Substitution

This block sits at the back end of a floating-point datapath. It receives a result that has already been normalized: a sign, a biased exponent that is not yet limited to the format's range, a 24-bit significand with its leading one present, and three bits below the significand (guard, round and sticky). A 2-bit rounding mode selects one of four IEEE rounding directions. The block rounds the significand, renormalizes when rounding carries out of the top bit, and packs a 32-bit single-precision word.

After rounding, the block checks the exponent. When the result is too large and the overflow trap is off, it substitutes the default overflow value. That value depends on both the mode and the sign. When the trap is on, it delivers the rounded value with its exponent wrapped down by 192, so that trap software can recover it. The block also reports tininess, measured after rounding on an unbounded exponent, for the underflow logic that follows it. Results are registered, one cycle after the inputs.

Top module: `fp_round_stage`

## Requirements
- R1: Mode code 0 rounds to nearest. A bit pattern below half (guard=0) truncates and one above half (guard=1 with round or sticky set) increments. An exact tie (guard=1, round=0, sticky=0) increments only when significand bit 0 is 1, so the delivered significand ends in 0.
- R2: Mode code 1 rounds toward zero. The significand is never incremented, whatever the sign and the discarded bits.
- R3: Mode code 2 rounds toward positive infinity. It increments when the sign is 0 and any of guard, round or sticky is 1, and otherwise truncates.
- R4: Mode code 3 rounds toward negative infinity. It increments when the sign is 1 and any of guard, round or sticky is 1, and otherwise truncates.
- R5: When an increment carries out of a significand of all ones, the delivered fraction field (bits 22..0) is zero and the exponent is one more than the input exponent. The overflow and tininess checks use this incremented exponent.
- R6: The overflow output is 1 exactly when the rounded exponent is 255 or more. It is reported whether or not the trap is enabled.
- R7: On overflow with ovf_trap_en=0, the delivered word has the input sign. It is infinity (exponent field 255, fraction 0) when the mode rounds away from zero: mode 0, mode 2 with sign 0, or mode 3 with sign 1. Otherwise it is the largest finite value (exponent field 254, fraction all ones).
- R8: The inexact output is 1 when any of guard, round or sticky is 1, or when an overflow occurs with ovf_trap_en=0.
- R9: On overflow with ovf_trap_en=1, the exponent field holds the low 8 bits of (rounded exponent - 192), and the fraction field holds the rounded fraction. Inexact then depends only on guard, round and sticky.
- R10: The tiny output is 1 exactly when the rounded exponent is below 1. In that case the delivered word is a zero carrying the input sign (bits 30..0 all zero).
- R11: Outputs are registered. Each input set appears on the outputs after the next rising clock edge. While rst is high the result word and all three flags are 0.
- R12: When no overflow or tininess occurs, the word holds the sign in bit 31, the low 8 bits of the rounded exponent in bits 30..23, and the rounded fraction in bits 22..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_sign | input | 1 | Sign of the value to round |
| in_exp | input | 10 | Biased exponent, two's complement, not yet range-limited |
| in_sig | input | 24 | Normalized significand, bit 23 is the leading one |
| in_guard | input | 1 | First bit below the significand |
| in_round | input | 1 | Second bit below the significand |
| in_sticky | input | 1 | OR of all further discarded bits |
| rnd_mode | input | 2 | Rounding direction code, 0 to 3 |
| ovf_trap_en | input | 1 | Overflow trap enable; 1 suppresses substitution |
| res_word | output | 32 | Packed single-precision result |
| res_inexact | output | 1 | Result differs from the exact value |
| res_overflow | output | 1 | Rounded exponent exceeded the finite range |
| res_tiny | output | 1 | Rounded result magnitude below 2^-126 |

## Verification
Directed vectors pin each mode against the four patterns of discarded bits: exactly zero, below half, exact tie and above half. They are run with both signs and with both significand parities. This separates nearest-even from the directed modes and positive infinity from negative infinity. Vectors with an all-ones significand at exponents 0 and 254 show that the carry-out feeds the tininess and overflow decisions, rather than the input exponent. Random vectors cluster the exponent near both range edges and cover every mode and trap setting, so each substitution choice and the trapped wrap are compared against a bench model.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST_EVEN = 2'd0,
    RM_TO_ZERO      = 2'd1,
    RM_UP           = 2'd2,
    RM_DOWN         = 2'd3
  } rmode_e;

  localparam int SIG_W   = 24;
  localparam int EXPF_W  = 8;
  localparam int XIN_W   = 10;
  localparam int WORD_W  = 1 + EXPF_W + SIG_W - 1;
endpackage

// File: rtl/fp_round_decide.sv
module fp_round_decide
  import fp_round_pkg::*;
(
  input  rmode_e mode,
  input  logic   sign,
  input  logic   lsb,
  input  logic   guard,
  input  logic   rbit,
  input  logic   sticky,
  output logic   inc,
  output logic   lost
);
  always_comb begin
    lost = guard | rbit | sticky;
    unique case (mode)
      RM_NEAREST_EVEN: inc = guard & (rbit | sticky | lsb);
      RM_TO_ZERO:      inc = 1'b0;
      RM_UP:           inc = ~sign & lost;
      RM_DOWN:         inc = sign & lost;
      default:         inc = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_round_add.sv
module fp_round_add #(
  parameter int SIG_W = 24,
  parameter int XIN_W = 10
) (
  input  logic [SIG_W-1:0]        sig_in,
  input  logic signed [XIN_W-1:0] exp_in,
  input  logic                    inc,
  output logic [SIG_W-1:0]        sig_out,
  output logic signed [XIN_W:0]   exp_out,
  output logic                    carry
);
  logic [SIG_W:0] sum;

  always_comb begin
    sum   = {1'b0, sig_in} + {{SIG_W{1'b0}}, inc};
    carry = sum[SIG_W];
    if (carry) sig_out = sum[SIG_W:1];
    else       sig_out = sum[SIG_W-1:0];
    exp_out = XIN_W'(1)'(0) + {exp_in[XIN_W-1], exp_in} + {{XIN_W{1'b0}}, carry};
  end
endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack
  import fp_round_pkg::*;
#(
  parameter int SIG_W  = 24,
  parameter int EXPF_W = 8,
  parameter int XIN_W  = 10
) (
  input  rmode_e                  mode,
  input  logic                    sign,
  input  logic                    trap_en,
  input  logic                    lost,
  input  logic [SIG_W-1:0]        sig_r,
  input  logic signed [XIN_W:0]   exp_r,
  output logic [EXPF_W+SIG_W-1:0] word,
  output logic                    inexact,
  output logic                    ovf,
  output logic                    tiny
);
  localparam int FRAC_W  = SIG_W - 1;
  localparam int EXP_TOP = (1 << EXPF_W) - 1;
  localparam int WRAP    = 3 * (1 << (EXPF_W - 2));
  localparam logic signed [XIN_W:0] OVF_AT  = (XIN_W+1)'(EXP_TOP);
  localparam logic signed [XIN_W:0] MIN_NRM = (XIN_W+1)'(1);
  localparam logic signed [XIN_W:0] WRAP_S  = (XIN_W+1)'(WRAP);

  logic                     away;
  logic signed [XIN_W:0]    exp_w;
  logic [EXPF_W+FRAC_W-1:0] mag;

  always_comb begin
    ovf   = exp_r >= OVF_AT;
    tiny  = exp_r < MIN_NRM;
    exp_w = exp_r - WRAP_S;
    unique case (mode)
      RM_NEAREST_EVEN: away = 1'b1;
      RM_TO_ZERO:      away = 1'b0;
      RM_UP:           away = ~sign;
      default:         away = sign;
    endcase
    if (ovf && !trap_en) begin
      if (away) mag = {EXPF_W'(EXP_TOP), {FRAC_W{1'b0}}};
      else      mag = {EXPF_W'(EXP_TOP - 1), {FRAC_W{1'b1}}};
    end else if (ovf) begin
      mag = {exp_w[EXPF_W-1:0], sig_r[FRAC_W-1:0]};
    end else if (tiny) begin
      mag = '0;
    end else begin
      mag = {exp_r[EXPF_W-1:0], sig_r[FRAC_W-1:0]};
    end
    word    = {sign, mag};
    inexact = lost | (ovf & ~trap_en);
  end
endmodule

// File: rtl/fp_round_stage.sv
module fp_round_stage
  import fp_round_pkg::*;
#(
  parameter int P_SIG_W  = SIG_W,
  parameter int P_EXPF_W = EXPF_W,
  parameter int P_XIN_W  = XIN_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_sign,
  input  logic [P_XIN_W-1:0]        in_exp,
  input  logic [P_SIG_W-1:0]        in_sig,
  input  logic                      in_guard,
  input  logic                      in_round,
  input  logic                      in_sticky,
  input  logic [1:0]                rnd_mode,
  input  logic                      ovf_trap_en,
  output logic [P_EXPF_W+P_SIG_W-1:0] res_word,
  output logic                      res_inexact,
  output logic                      res_overflow,
  output logic                      res_tiny
);
  localparam int OUT_W = P_EXPF_W + P_SIG_W;

  rmode_e                     mode;
  logic                       inc, lost, carry;
  logic [P_SIG_W-1:0]         sig_r;
  logic signed [P_XIN_W:0]    exp_r;
  logic [OUT_W-1:0]           word_c;
  logic                       inexact_c, ovf_c, tiny_c;

  assign mode = rmode_e'(rnd_mode);

  fp_round_decide u_decide (
    .mode(mode), .sign(in_sign), .lsb(in_sig[0]), .guard(in_guard),
    .rbit(in_round), .sticky(in_sticky), .inc(inc), .lost(lost)
  );

  fp_round_add #(.SIG_W(P_SIG_W), .XIN_W(P_XIN_W)) u_add (
    .sig_in(in_sig), .exp_in($signed(in_exp)), .inc(inc),
    .sig_out(sig_r), .exp_out(exp_r), .carry(carry)
  );

  fp_round_pack #(.SIG_W(P_SIG_W), .EXPF_W(P_EXPF_W), .XIN_W(P_XIN_W)) u_pack (
    .mode(mode), .sign(in_sign), .trap_en(ovf_trap_en), .lost(lost),
    .sig_r(sig_r), .exp_r(exp_r), .word(word_c), .inexact(inexact_c),
    .ovf(ovf_c), .tiny(tiny_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_word     <= '0;
      res_inexact  <= 1'b0;
      res_overflow <= 1'b0;
      res_tiny     <= 1'b0;
    end else begin
      res_word     <= word_c;
      res_inexact  <= inexact_c;
      res_overflow <= ovf_c;
      res_tiny     <= tiny_c;
    end
  end

  // R2
  rz_no_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == RM_TO_ZERO) |-> !inc);

  // R1
  inc_needs_lost_chk: assert property (@(posedge clk) disable iff (rst)
    inc |-> (in_guard | in_round | in_sticky));

  // R5
  carry_zero_frac_chk: assert property (@(posedge clk) disable iff (rst)
    carry |-> (sig_r[P_SIG_W-2:0] == '0));

  // R10
  tiny_zero_mag_chk: assert property (@(posedge clk) disable iff (rst)
    res_tiny |-> (res_word[OUT_W-2:0] == '0));

  // R8
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
    (res_overflow && !$past(ovf_trap_en)) |-> res_inexact);

  // R6
  no_ovf_and_tiny_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_overflow && res_tiny));

  // R11
  sign_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_word[OUT_W-1] == $past(in_sign)));
endmodule

// File: tb/fp_round_stage_test.sv
module fp_round_stage_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_sign;
  logic [9:0]  in_exp;
  logic [23:0] in_sig;
  logic        in_guard, in_round, in_sticky;
  logic [1:0]  rnd_mode;
  logic        ovf_trap_en;
  logic [31:0] res_word;
  logic        res_inexact, res_overflow, res_tiny;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_round_stage uut (
    .clk(clk), .rst(rst), .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
    .in_guard(in_guard), .in_round(in_round), .in_sticky(in_sticky),
    .rnd_mode(rnd_mode), .ovf_trap_en(ovf_trap_en), .res_word(res_word),
    .res_inexact(res_inexact), .res_overflow(res_overflow), .res_tiny(res_tiny)
  );

  typedef struct packed {
    logic [31:0] word;
    logic inx, ovf, tny;
  } exp_t;

  function automatic exp_t model(input logic s, input logic [9:0] e, input logic [23:0] m,
                                 input logic g, input logic r, input logic st,
                                 input logic [1:0] md, input logic trap);
    exp_t o;
    logic lost, up, away;
    int ex;
    logic [24:0] sum;
    logic [22:0] frac;
    lost = g | r | st;
    case (md)
      2'd0: up = g && (r || st || m[0]);
      2'd1: up = 1'b0;
      2'd2: up = !s && lost;
      default: up = s && lost;
    endcase
    ex  = $signed(e);
    sum = {1'b0, m} + 25'(up);
    if (sum[24]) begin frac = 23'd0; ex = ex + 1; end
    else frac = sum[22:0];
    o.ovf = ex >= 255;
    o.tny = ex < 1;
    away  = (md == 2'd0) || (md == 2'd2 && !s) || (md == 2'd3 && s);
    if (o.ovf && !trap)      o.word = away ? {s, 8'hFF, 23'd0} : {s, 8'hFE, 23'h7FFFFF};
    else if (o.ovf)          o.word = {s, 8'(ex - 192), frac};
    else if (o.tny)          o.word = {s, 31'd0};
    else                     o.word = {s, 8'(ex), frac};
    o.inx = lost || (o.ovf && !trap);
    return o;
  endfunction

  function automatic string tag_for(input exp_t x, input logic [1:0] md, input logic trap,
                                    input logic [23:0] m);
    if (x.tny) return "R10";
    if (x.ovf) return trap ? "R9" : "R7";
    if (m == 24'hFFFFFF) return "R5";
    case (md)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic s, input int e, input logic [23:0] m,
                       input logic g, input logic r, input logic st,
                       input logic [1:0] md, input logic trap);
    exp_t x;
    string t;
    in_sign = s; in_exp = 10'(e); in_sig = m; in_guard = g; in_round = r;
    in_sticky = st; rnd_mode = md; ovf_trap_en = trap;
    x = model(s, 10'(e), m, g, r, st, md, trap);
    t = tag_for(x, md, trap, m);
    @(negedge clk);
    vectors++;
    if (res_word !== x.word) begin
      miscompares++;
      $display("FAIL %s/R12 word: actual %h expected %h", t, res_word, x.word);
    end
    if (res_inexact !== x.inx) begin
      miscompares++;
      $display("FAIL R8 inexact: actual %b expected %b", res_inexact, x.inx);
    end
    if (res_overflow !== x.ovf) begin
      miscompares++;
      $display("FAIL R6 overflow: actual %b expected %b", res_overflow, x.ovf);
    end
    if (res_tiny !== x.tny) begin
      miscompares++;
      $display("FAIL R10 tiny: actual %b expected %b", res_tiny, x.tny);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; in_sign = 1'b1; in_exp = 10'd300; in_sig = 24'hFFFFFF;
    in_guard = 1'b1; in_round = 1'b1; in_sticky = 1'b1; rnd_mode = 2'd0; ovf_trap_en = 1'b0;
    repeat (3) @(negedge clk);
    vectors++;
    // R11 reset state
    if ({res_word, res_inexact, res_overflow, res_tiny} !== 35'd0) begin
      miscompares++;
      $display("FAIL R11 reset: actual %h expected 0",
               {res_word, res_inexact, res_overflow, res_tiny});
    end
    rst = 1'b0;

    // R1 tie to even: odd rounds up, even stays
    apply(0, 127, 24'h800001, 1, 0, 0, 2'd0, 0);
    apply(0, 127, 24'h800002, 1, 0, 0, 2'd0, 0);
    apply(1, 130, 24'h9ABCDE, 0, 1, 1, 2'd0, 0);
    apply(1, 130, 24'h9ABCDE, 1, 0, 1, 2'd0, 0);
    // R2 toward zero
    apply(0, 100, 24'hC00000, 1, 1, 1, 2'd1, 0);
    apply(1, 100, 24'hC00000, 1, 1, 1, 2'd1, 0);
    // R3 toward +inf
    apply(0, 100, 24'hC00000, 0, 0, 1, 2'd2, 0);
    apply(1, 100, 24'hC00000, 0, 0, 1, 2'd2, 0);
    // R4 toward -inf
    apply(0, 100, 24'hC00000, 0, 0, 1, 2'd3, 0);
    apply(1, 100, 24'hC00000, 0, 0, 1, 2'd3, 0);
    // R8 exact value, no flag
    apply(0, 140, 24'hA00000, 0, 0, 0, 2'd2, 0);
    // R5 carry renormalize, and carry into overflow / out of tininess
    apply(0, 127, 24'hFFFFFF, 1, 1, 0, 2'd0, 0);
    apply(0, 254, 24'hFFFFFF, 1, 0, 0, 2'd0, 0);
    apply(0, 0,   24'hFFFFFF, 1, 0, 0, 2'd0, 0);
    apply(0, 0,   24'hFFFFFF, 1, 0, 0, 2'd1, 0);
    // R7 substitution across modes and signs
    for (int md = 0; md < 4; md++) begin
      apply(0, 260, 24'h800000, 0, 0, 0, 2'(md), 0);
      apply(1, 260, 24'h800000, 0, 0, 0, 2'(md), 0);
    end
    // R9 trapped overflow wrap
    apply(1, 300, 24'h812345, 0, 0, 0, 2'd1, 1);
    apply(0, 254, 24'hFFFFFF, 1, 1, 1, 2'd2, 1);
    // R10 tiny
    apply(1, -5, 24'h876543, 1, 1, 1, 2'd3, 0);
    apply(0, 1, 24'h800000, 0, 0, 0, 2'd0, 0);
    // R12 random sweep near edges
    for (int i = 0; i < 2000; i++) begin
      int e;
      case ($urandom_range(0, 2))
        0: e = $urandom_range(0, 6) - 3;
        1: e = 250 + $urandom_range(0, 12);
        default: e = $urandom_range(0, 1023) - 512;
      endcase
      apply($urandom_range(0, 1), e,
            {1'b1, 23'($urandom_range(0, 3) == 0 ? 23'h7FFFFF : 23'($urandom))},
            $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            2'($urandom_range(0, 3)), $urandom_range(0, 1));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule